// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt lines into two requests for a processor: a normal request and a fast request. Each line has its own sensing setup. A trigger-type bit picks level or edge detection, and a polarity bit picks the active sense. Together the two bits make each line a high-level, low-level, rising-edge or falling-edge detector.

Edges are caught in per-line latches that hold until software acknowledges them by writing ones. Level lines report their live, polarity-adjusted state. The pending word is combined with an enable word to form a status word. A routing word then sends each enabled, pending line to either the normal or the fast request output.

Software reaches the controller through a plain word-aligned register port. The port has a byte address, write data, a write strobe, a read strobe and registered read data. Input synchronisation, priority encoding and bus error responses belong to surrounding logic.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, the enable, polarity, trigger-type and routing words read as zero and all edge latches are clear. With every input held high at reset, the pending and status words read zero and both request outputs are low.
- R2: The configuration words are stored and read back unchanged at these byte offsets: enable at 0x00, polarity at 0x0C, trigger-type at 0x10 and routing at 0x14. A write takes effect at the clock edge where the write strobe is sampled. Read data appears on `rdata_o` at the clock edge where the read strobe is sampled and holds until the next read.
- R3: A line with trigger-type 0 is level sensed, and its pending bit (offset 0x04) equals the input when polarity is 1 and the inverted input when polarity is 0. Writing 1 to that pending bit does not clear it while the level stays active.
- R4: A line with trigger-type 1 is edge sensed. With polarity 1, a 0-to-1 input change, measured against the input's value on the previous clock, sets its latch. With polarity 0, a 1-to-0 change sets it. The opposite change leaves the latch unchanged, and a set latch reads as 1 in the pending word.
- R5: Writing the pending word at 0x04 clears every edge latch whose write-data bit is 1, and leaves latches whose bit is 0 unchanged.
- R6: When a new edge and a clearing write reach the same latch in one cycle, the latch ends up set.
- R7: The status word at 0x08 reads as pending AND enable. Writes to 0x08 change no register and no latch.
- R8: `irq_o` is the OR of status bits whose routing bit is 0, and `fiq_o` is the OR of status bits whose routing bit is 1. Both are combinational, so a change in the pending or enable word shows on them within the same cycle.
- R9: While a line's trigger-type is 0, its edge latch is held clear. After switching back to edge mode, the line shows no pending edge until a new one arrives.
- R10: Reads of any offset other than the six listed return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source lines, already synchronous to clk_i |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | NUM_SRC | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with its default parameters: 32 sources and a 5-bit byte address. Every source bit is then reachable, as are the two unmapped word offsets 0x18 and 0x1C. Neighbouring lines are given different modes at once (rising, falling, high, low) so that one pending read shows whether each bit kept its own detector. Clear-versus-edge collisions, writes to the read-only status word and mode switches that strand a latch are driven through the register port and observed through pending reads and the two request pins.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // word index = byte address >> 2
  typedef enum logic [2:0] {
    SEL_ENA  = 3'd0,
    SEL_PEND = 3'd1,
    SEL_STAT = 3'd2,
    SEL_POL  = 3'd3,
    SEL_TRIG = 3'd4,
    SEL_ROUT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC-1:0] ena_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] trig_o,
  output logic [NUM_SRC-1:0] rout_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] ena_q, pol_q, trig_q, rout_q, rdata_q, rd_mux;
  logic               hit_ena, hit_pend, hit_stat, hit_pol, hit_trig, hit_rout;

  assign idx      = addr_i[ADDR_W-1:2];
  assign hit_ena  = (idx == IDX_W'(SEL_ENA));
  assign hit_pend = (idx == IDX_W'(SEL_PEND));
  assign hit_stat = (idx == IDX_W'(SEL_STAT));
  assign hit_pol  = (idx == IDX_W'(SEL_POL));
  assign hit_trig = (idx == IDX_W'(SEL_TRIG));
  assign hit_rout = (idx == IDX_W'(SEL_ROUT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q  <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      rout_q <= '0;
    end else if (we_i) begin
      if (hit_ena)  ena_q  <= wdata_i;
      if (hit_pol)  pol_q  <= wdata_i;
      if (hit_trig) trig_q <= wdata_i;
      if (hit_rout) rout_q <= wdata_i;
    end
  end

  // write-one-to-clear strobe toward the edge latches
  assign clr_o = (we_i && hit_pend) ? wdata_i : '0;

  always_comb begin
    rd_mux = '0;
    if (hit_ena)  rd_mux = ena_q;
    if (hit_pend) rd_mux = pend_i;
    if (hit_stat) rd_mux = stat_i;
    if (hit_pol)  rd_mux = pol_q;
    if (hit_trig) rd_mux = trig_q;
    if (hit_rout) rd_mux = rout_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign ena_o   = ena_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign rout_o  = rout_q;
  assign rdata_o = rdata_q;

  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_trig) |=> (trig_q == $past(wdata_i)));

  assert_stat_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_stat) |=> ($stable(ena_q) && $stable(pol_q) && $stable(trig_q) && $stable(rout_q)));
endmodule

// File: rtl/irq_ctrl_detect.sv
module irq_ctrl_detect #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic prev_q, latch_q, active, edge_hit;

    assign active   = pol_i[g] ? src_i[g] : ~src_i[g];
    assign edge_hit = pol_i[g] ? (src_i[g] & ~prev_q) : (~src_i[g] & prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q  <= src_i[g];
        // new edge beats a same-cycle clear; level mode drops the latch
        latch_q <= trig_i[g] & (edge_hit | (latch_q & ~clr_i[g]));
      end
    end

    assign pend_o[g] = trig_i[g] ? latch_q : active;

    assert_edge_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[g] && edge_hit) |=> latch_q);

    assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[g] && latch_q && clr_i[g] && !edge_hit) |=> !latch_q);

    assert_edge_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[g] && edge_hit && clr_i[g]) |=> latch_q);

    assert_level_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trig_i[g] |=> !latch_q);
  end
endmodule

// File: rtl/irq_ctrl_route.sv
module irq_ctrl_route #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] ena_i,
  input  logic [NUM_SRC-1:0] rout_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic               irq_o,
  output logic               fiq_o
);
  assign stat_o = pend_i & ena_i;
  assign irq_o  = |(stat_o & ~rout_i);
  assign fiq_o  = |(stat_o & rout_i);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] ena, pol, trig, rout, clr, pend, stat;

  irq_ctrl_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .re_i    (re_i),
    .pend_i  (pend),
    .stat_i  (stat),
    .ena_o   (ena),
    .pol_o   (pol),
    .trig_o  (trig),
    .rout_o  (rout),
    .clr_o   (clr),
    .rdata_o (rdata_o)
  );

  irq_ctrl_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pol_i  (pol),
    .trig_i (trig),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_ctrl_route #(.NUM_SRC(NUM_SRC)) u_route (
    .pend_i (pend),
    .ena_i  (ena),
    .rout_i (rout),
    .stat_o (stat),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o)
  );

  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena == '0) |-> (!irq_o && !fiq_o));

  assert_no_fast_route_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rout == '0) |-> !fiq_o);

  assert_level_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig == '0 && pol == '1) |-> (pend == src_i));
endmodule

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
  localparam int NS = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '1;
  logic [AW-1:0] addr = '0;
  logic [NS-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [NS-1:0] rdata;
  logic          irq, fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [NS-1:0] exp;
    string         tag;
  } rd_item_t;
  rd_item_t rd_q[$];

  always #2 clk = ~clk;

  irq_ctrl_top #(.NUM_SRC(NS), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NS-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: pushes expectation, monitor compares
  task automatic rd(logic [AW-1:0] a, logic [NS-1:0] exp, string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    rd_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk);
    src = v;
  endtask

  initial begin : monitor
    rd_item_t it;
    forever begin
      @(posedge clk);
      if (re) begin
        @(negedge clk);
        if (rd_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected read act=%h exp=none", rdata);
        end else begin
          it = rd_q.pop_front();
          check(it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [NS-1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 fiq", {31'b0, fiq}, '0);
    rd(5'h00, '0, "R1 enable");
    rd(5'h04, '0, "R1 pending");
    rd(5'h08, '0, "R1 status");
    rd(5'h0C, '0, "R1 polarity");
    rd(5'h10, '0, "R1 trigger");
    rd(5'h14, '0, "R1 routing");
    // R10 unmapped
    rd(5'h18, '0, "R10 0x18");
    rd(5'h1C, '0, "R10 0x1C");
    // R2 readback
    wr(5'h00, 32'hA5A5F00F); rd(5'h00, 32'hA5A5F00F, "R2 enable");
    wr(5'h0C, 32'h12345678); rd(5'h0C, 32'h12345678, "R2 polarity");
    wr(5'h10, 32'h0F0F0F0F); rd(5'h10, 32'h0F0F0F0F, "R2 trigger");
    wr(5'h14, 32'hC3C3C3C3); rd(5'h14, 32'hC3C3C3C3, "R2 routing");
    rd(5'h18, '0, "R10 after config");
    wr(5'h00, '0); wr(5'h0C, '0); wr(5'h10, '0); wr(5'h14, '0);
    // R3 level sensing
    wr(5'h0C, 32'h0000_0003);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0000_0003, "R3 high level");
    check("R3 irq", {31'b0, irq}, 32'h1);
    s = '1; s[0] = 1'b0; s[5] = 1'b0;
    set_src(s);
    rd(5'h04, 32'h0000_0022, "R3 mixed level");
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0000_0022, "R3 clear ignored on level");
    check("R3 irq held", {31'b0, irq}, 32'h1);
    set_src('1);
    wr(5'h0C, '0);
    check("R3 irq idle", {31'b0, irq}, '0);
    // R4 edges: bits 8-11 rising, 12-15 falling
    wr(5'h0C, 32'h0000_0F00);
    wr(5'h10, 32'h0000_FF00);
    s = '1; s[8] = 1'b0; s[12] = 1'b0;
    set_src(s);
    rd(5'h04, 32'h0000_1000, "R4 falling latched, fall on rising ignored");
    s[8] = 1'b1;
    set_src(s);
    rd(5'h04, 32'h0000_1100, "R4 rising latched");
    s[12] = 1'b1;
    set_src(s);
    rd(5'h04, 32'h0000_1100, "R4 rise on falling ignored");
    check("R8 irq edge", {31'b0, irq}, 32'h1);
    // R5 write-one-to-clear
    wr(5'h04, 32'h0000_0100);
    rd(5'h04, 32'h0000_1000, "R5 clear one");
    wr(5'h04, 32'h0000_0000);
    rd(5'h04, 32'h0000_1000, "R5 zero no effect");
    wr(5'h04, 32'h0000_1000);
    rd(5'h04, 32'h0000_0000, "R5 clear all");
    // R6 edge wins over clear in same cycle
    s[9] = 1'b0; set_src(s);
    s[9] = 1'b1; set_src(s);
    rd(5'h04, 32'h0000_0200, "R6 setup");
    @(negedge clk);
    s[12] = 1'b0; src = s;
    addr = 5'h04; wdata = 32'h0000_1200; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(5'h04, 32'h0000_1000, "R6 edge beats clear");
    // R7 status and read-only
    wr(5'h00, 32'hFFFF_0FFF);
    rd(5'h08, 32'h0000_0000, "R7 masked status");
    check("R7 irq masked", {31'b0, irq}, '0);
    wr(5'h00, 32'h0000_1000);
    rd(5'h08, 32'h0000_1000, "R7 enabled status");
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0000_1000, "R7 pending after status write");
    rd(5'h00, 32'h0000_1000, "R7 enable after status write");
    rd(5'h08, 32'h0000_1000, "R7 status after status write");
    // R8 routing
    check("R8 normal irq", {31'b0, irq}, 32'h1);
    check("R8 normal fiq", {31'b0, fiq}, '0);
    wr(5'h14, 32'h0000_1000);
    check("R8 fast irq", {31'b0, irq}, '0);
    check("R8 fast fiq", {31'b0, fiq}, 32'h1);
    wr(5'h00, '0);
    check("R8 masked fiq", {31'b0, fiq}, '0);
    // R9 level mode drops latch (src[12] low, pol 0: active in level)
    wr(5'h10, 32'h0000_EF00);
    rd(5'h04, 32'h0000_1000, "R9 level active");
    wr(5'h10, 32'h0000_FF00);
    rd(5'h04, 32'h0000_0000, "R9 no stale edge");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule